// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block sequences one synchronous-rectifier gate from digitized views of its switch's drain-to-source voltage. Three comparator flags arrive on every clock: below the negative turn-on level, above the turn-off level, and above zero. A turn-on is considered only after the turn-on flag has held without a break for a debounce window. A request then goes to a neighbouring interlock, and the gate rises once that interlock grants permission.

While the gate is on, the block counts the conduction time. The turn-off comparator is masked for the first half of each conduction. In that half only the zero-crossing flag can end it, so a reverse current is still caught. The half-point is half the length measured in the previous conduction. Before any length has been measured, a fixed default minimum is used instead. After turn-off, the block stays in hold-off until the drain has been seen above zero. This means the negative jump that comes with body-diode conduction cannot cause a second turn-on in the same cycle.

All times are counted in clock cycles. `rst_n` is an asynchronous active-low reset, and its release is expected to be synchronous to `clk`.

Top module: `sr_gate_sequencer`

## Requirements
- R1: `on_req_o` rises in the cycle after `vds_below_on_i` has been sampled high on DEB_CYC consecutive rising edges, counting from the armed state. DEB_CYC must be at least 2.
- R2: If `vds_below_on_i` is sampled low before the debounce completes, no request is made. A later debounce starts again from zero.
- R3: During conduction, `vds_above_off_i` has no effect while the number of completed conduction cycles is below the half-point H. The gate stays high.
- R4: During conduction, `vds_above_zero_i` sampled high ends conduction, including within the masked half. `gate_o` is low in the next cycle.
- R5: H equals the previous conduction length divided by two, rounded down.
- R6: Once the completed conduction cycles reach H, `vds_above_off_i` sampled high drives `gate_o` low in the next cycle.
- R7: After a turn-off, `vds_below_on_i` is ignored until `vds_above_zero_i` has been sampled high. After that, the channel is armed again.
- R8: The conduction length is the number of cycles `gate_o` was high. It saturates at 2^CNT_W-1.
- R9: Until the first conduction has been measured after reset, H equals DEF_MIN_ON.
- R10: `on_req_o` stays high until `permit_i` is sampled high, and `gate_o` rises in the next cycle. If `vds_below_on_i` is sampled low first, the request is withdrawn without a turn-on.
- R11: During reset, `gate_o` and `on_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vds_below_on_i | input | 1 | Drain voltage is below the turn-on level |
| vds_above_off_i | input | 1 | Drain voltage is above the turn-off level |
| vds_above_zero_i | input | 1 | Drain voltage is above zero |
| permit_i | input | 1 | Interlock permission to switch on |
| on_req_o | output | 1 | Turn-on request to the interlock |
| gate_o | output | 1 | Gate enable |

## Verification
The bench builds the block with DEB_CYC=4, CNT_W=5 and DEF_MIN_ON=6. A debounce therefore completes in four edges. A measured length tops out at 31, so a 40-cycle conduction exercises saturation and, through it, a half-point of 15. Conductions with the turn-off flag held from the start fall after 7, 4 and 3 cycles. This follows the default half-point first and then the halving of each measured length, and it also leads to a half-point of zero, which has no masking at all.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
  typedef enum logic [2:0] {
    ST_ARMED,
    ST_DEBOUNCE,
    ST_REQUEST,
    ST_CONDUCT,
    ST_HOLDOFF
  } seq_state_t;
endpackage

// File: rtl/sr_debounce.sv
module sr_debounce #(
  parameter int DEB_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic level_i,
  output logic done_o
);
  localparam int DW = $clog2(DEB_CYC + 1);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i | (run_i & level_i);
    cnt_d  = start_i ? DW'(1) : cnt_q + DW'(1);
    done_o = run_i & level_i & (cnt_q == DW'(DEB_CYC - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // a completed debounce needs the level seen on the previous edge too
  AST_DEB_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(level_i)); // R1
endmodule

// File: rtl/sr_cond_timer.sv
module sr_cond_timer #(
  parameter int CNT_W      = 10,
  parameter int DEF_MIN_ON = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic stop_i,
  output logic blank_o
);
  localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] len_d;
  logic [CNT_W-1:0] len_inc;
  logic             len_en;
  logic [CNT_W-1:0] prev_q;
  logic             prev_vld_q;
  logic [CNT_W-1:0] half;

  always_comb begin
    len_inc = (len_q == LEN_MAX) ? LEN_MAX : len_q + 1'b1;
    len_en  = active_i | (len_q != '0);
    len_d   = (active_i && !stop_i) ? len_inc : '0;
    half    = prev_vld_q ? (prev_q >> 1) : CNT_W'(DEF_MIN_ON);
    blank_o = active_i && (len_q < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (stop_i) begin
      prev_q     <= len_inc;
      prev_vld_q <= 1'b1;
    end
  end

  AST_LEN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !stop_i && len_q == LEN_MAX) |=> (len_q == LEN_MAX)); // R8
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_on_i,
  input  logic       above_off_i,
  input  logic       above_zero_i,
  input  logic       permit_i,
  input  logic       deb_done_i,
  input  logic       blank_i,
  output seq_state_t state_o,
  output logic       deb_start_o,
  output logic       deb_run_o,
  output logic       cond_active_o,
  output logic       cond_stop_o
);
  seq_state_t state_q;
  seq_state_t state_d;

  always_comb begin
    deb_start_o   = (state_q == ST_ARMED) && below_on_i;
    deb_run_o     = (state_q == ST_DEBOUNCE);
    cond_active_o = (state_q == ST_CONDUCT);
    cond_stop_o   = cond_active_o && (above_zero_i || (above_off_i && !blank_i));
    state_d       = state_q;
    case (state_q)
      ST_ARMED:    if (below_on_i) state_d = ST_DEBOUNCE;
      ST_DEBOUNCE: begin
        if (!below_on_i)     state_d = ST_ARMED;
        else if (deb_done_i) state_d = ST_REQUEST;
      end
      ST_REQUEST: begin
        if (!below_on_i)   state_d = ST_ARMED;
        else if (permit_i) state_d = ST_CONDUCT;
      end
      ST_CONDUCT:  if (cond_stop_o) state_d = ST_HOLDOFF;
      ST_HOLDOFF:  if (above_zero_i) state_d = ST_ARMED;
      default:     state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  AST_HOLDOFF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLDOFF && !above_zero_i) |=> (state_q == ST_HOLDOFF)); // R7
endmodule

// File: rtl/sr_gate_sequencer.sv
module sr_gate_sequencer
  import sr_seq_pkg::*;
#(
  parameter int DEB_CYC    = 13,
  parameter int CNT_W      = 10,
  parameter int DEF_MIN_ON = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vds_below_on_i,
  input  logic vds_above_off_i,
  input  logic vds_above_zero_i,
  input  logic permit_i,
  output logic on_req_o,
  output logic gate_o
);
  seq_state_t state;
  logic       deb_start;
  logic       deb_run;
  logic       deb_done;
  logic       cond_active;
  logic       cond_stop;
  logic       blank;

  sr_debounce #(.DEB_CYC(DEB_CYC)) i_debounce (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (deb_start),
    .run_i   (deb_run),
    .level_i (vds_below_on_i),
    .done_o  (deb_done)
  );

  sr_cond_timer #(.CNT_W(CNT_W), .DEF_MIN_ON(DEF_MIN_ON)) i_cond_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (cond_active),
    .stop_i   (cond_stop),
    .blank_o  (blank)
  );

  sr_seq_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .below_on_i    (vds_below_on_i),
    .above_off_i   (vds_above_off_i),
    .above_zero_i  (vds_above_zero_i),
    .permit_i      (permit_i),
    .deb_done_i    (deb_done),
    .blank_i       (blank),
    .state_o       (state),
    .deb_start_o   (deb_start),
    .deb_run_o     (deb_run),
    .cond_active_o (cond_active),
    .cond_stop_o   (cond_stop)
  );

  always_comb begin
    on_req_o = (state == ST_REQUEST);
    gate_o   = (state == ST_CONDUCT);
  end

  AST_REQ_AFTER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_req_o) |-> $past(vds_below_on_i)); // R1
  AST_GATE_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> $past(on_req_o && permit_i)); // R10
  AST_ZERO_CUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && vds_above_zero_i) |=> !gate_o); // R4
  AST_MASK_HOLDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && blank && !vds_above_zero_i) |=> gate_o); // R3
  AST_LATE_OFF_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !blank && vds_above_off_i) |=> !gate_o); // R6
endmodule

// File: tb/test_sr_gate_sequencer.sv
module test_sr_gate_sequencer;
  localparam int DEB = 4;
  localparam int CW  = 5;
  localparam int DMO = 6;

  logic clk;
  logic rst_n;
  logic below_on;
  logic above_off;
  logic above_zero;
  logic permit;
  logic on_req;
  logic gate;

  int n_chk;
  int n_fail;
  bit done;

  sr_gate_sequencer #(.DEB_CYC(DEB), .CNT_W(CW), .DEF_MIN_ON(DMO)) i_sr_gate_sequencer (
    .clk              (clk),
    .rst_n            (rst_n),
    .vds_below_on_i   (below_on),
    .vds_above_off_i  (above_off),
    .vds_above_zero_i (above_zero),
    .permit_i         (permit),
    .on_req_o         (on_req),
    .gate_o           (gate)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_holdoff();
    above_zero = 1'b1;
    step();
    above_zero = 1'b0;
  endtask

  task automatic turn_on(input string tag);
    above_off = 1'b0; above_zero = 1'b0;
    below_on = 1'b1; permit = 1'b1;
    repeat (DEB - 1) step();
    chk(on_req, 1'b0, {tag, " R1 early"});
    step();
    chk(on_req, 1'b1, {tag, " R1 request"});
    step();
    chk(gate, 1'b1, {tag, " R10 gate up"});
    below_on = 1'b0;
  endtask

  task automatic off_by_comparator(input int h, input string tag);
    above_off = 1'b1;
    for (int i = 0; i < h; i++) begin
      step();
      chk(gate, 1'b1, {tag, " R3 masked"});
    end
    step();
    chk(gate, 1'b0, {tag, " R6 off"});
    above_off = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; below_on = 1'b0; above_off = 1'b0; above_zero = 1'b0; permit = 1'b0;
    repeat (3) step();
    chk(gate, 1'b0, "R11 gate");
    chk(on_req, 1'b0, "R11 req");
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_default_half();
    turn_on("R9");
    off_by_comparator(DMO, "R9 default half");
    clear_holdoff();
  endtask

  task automatic t_halving();
    turn_on("R5");
    off_by_comparator(3, "R5 half of 7");
    clear_holdoff();
  endtask

  task automatic t_holdoff();
    turn_on("R7");
    off_by_comparator(2, "R7 half of 4");
    below_on = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(on_req, 1'b0, "R7 no retrigger req");
      chk(gate, 1'b0, "R7 no retrigger gate");
    end
    below_on = 1'b0;
    clear_holdoff();
    turn_on("R7 rearmed");
  endtask

  task automatic t_zero_cut();
    above_zero = 1'b1;
    step();
    chk(gate, 1'b0, "R4 zero cut in masked half");
    step();
    above_zero = 1'b0;
  endtask

  task automatic t_broken_debounce();
    permit = 1'b0;
    below_on = 1'b1;
    repeat (DEB - 1) step();
    below_on = 1'b0;
    step();
    chk(on_req, 1'b0, "R2 broken");
    below_on = 1'b1;
    repeat (DEB - 1) step();
    chk(on_req, 1'b0, "R2 restart");
    step();
    chk(on_req, 1'b1, "R2 full count");
    below_on = 1'b0;
    step();
    chk(on_req, 1'b0, "R2 drop");
  endtask

  task automatic t_permit();
    permit = 1'b0;
    below_on = 1'b1;
    repeat (DEB) step();
    chk(on_req, 1'b1, "R10 req");
    repeat (3) step();
    chk(on_req, 1'b1, "R10 req held");
    chk(gate, 1'b0, "R10 waits for permit");
    below_on = 1'b0;
    step();
    chk(on_req, 1'b0, "R10 withdrawn");
    permit = 1'b1;
    step();
    chk(gate, 1'b0, "R10 no late gate");
    permit = 1'b0;
    below_on = 1'b1;
    repeat (DEB) step();
    chk(on_req, 1'b1, "R10 req again");
    permit = 1'b1;
    step();
    chk(gate, 1'b1, "R10 gate on permit");
    chk(on_req, 1'b0, "R10 req cleared");
    below_on = 1'b0;
    above_off = 1'b1;
    step();
    chk(gate, 1'b0, "R6 zero half");
    above_off = 1'b0;
    clear_holdoff();
  endtask

  task automatic t_saturate();
    turn_on("R8");
    for (int i = 0; i < 40; i++) begin
      step();
      chk(gate, 1'b1, "R8 long hold");
    end
    above_zero = 1'b1;
    step();
    chk(gate, 1'b0, "R4 zero end");
    step();
    above_zero = 1'b0;
    turn_on("R8 next");
    off_by_comparator(15, "R8 saturated half");
    clear_holdoff();
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_default_half();
    t_halving();
    t_holdoff();
    t_zero_cut();
    t_broken_debounce();
    t_permit();
    t_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule